// File: doc/BRIEF.md
# Interprocessor Mailbox Hub

This block lets several processors on one chip pass 32-bit messages to each other through a register bus. It holds a set of one-way mailboxes. Each mailbox is a small first-in first-out queue, and each has a fixed receiving processor, called a user here. A sender writes a word to the mailbox's message register. The receiver reads the same register to take out the oldest word. A per-mailbox count register reports how many words are waiting.

Each user owns a bank of four registers:

- a raw event status word;
- a write-one-to-clear view of that status;
- a write-one-to-set enable view;
- a write-one-to-clear enable view.

Each mailbox owns two status bits in its receiver's bank. Bit 2*M is the new-message bit. Bit 2*M+1 is the overflow bit. Every user has one registered, active-high interrupt line. It is high when any status bit of that user is set together with its enable bit.

The bus is a plain strobe interface. A write strobe lasts one cycle. Read data is combinational from the address. A read of a message register removes the head word at the clock edge where the read strobe is high. The bus has no back-pressure. A write to a full mailbox is dropped and recorded as an overflow, not stalled.

Top module: `mbx_hub`

## Requirements
- R1: After reset every mailbox is empty, every status and enable word is 0, and every `irq` bit is 0.
- R2: A write to offset 0x040+4*M adds a word to mailbox M. A read there returns the oldest word and removes it. A read of an empty mailbox returns 0 and changes nothing.
- R3: A read of offset 0x0C0+4*M returns the number of words held in mailbox M, from 0 to DEPTH.
- R4: A write to a mailbox that holds DEPTH words is dropped. The count stays at DEPTH and bit 2*M+1 of the receiving user's status is set.
- R5: Bit 2*M of the receiving user's status is set one cycle after mailbox M becomes non-empty. It cannot be cleared while words remain, and it stays set after the mailbox drains until it is cleared.
- R6: Bank offset +0x4 clears each status bit written as 1, and bits written as 0 are unchanged. Offset +0x0 reads the raw status. Offset +0x4 reads status AND enable.
- R7: Bank offset +0x8 sets each enable bit written as 1, and bits written as 0 are unchanged. Offsets +0x8 and +0xC both read the enable mask.
- R8: Bank offset +0xC clears each enable bit written as 1.
- R9: `irq[u]` is active high. It equals the OR of (status AND enable) of user u as that value stood one clock earlier.
- R10: Mailbox M sets bits only in the bank of user RX_MAP[4*M+:4]. The bank of user u sits at 0x100+0x10*u.
- R11: When both strobes are high, only the write takes effect and no word is removed. Reads of undecoded offsets return 0. Writes to count or raw-status registers, and writes to undecoded offsets, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; removes the head word on a message register |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data for bus_addr |
| irq | output | N_USER | Registered interrupt line per user |

## Verification
The bench uses the default parameters: ten mailboxes, four users, a queue depth of four, and the default routing table. With a depth of four, the full and overflow corners are reached after five writes. With this routing table, a mailbox that feeds user 1 can be checked against the silent banks of users 0, 2 and 3. The mailbox feeding user 2 exercises the combined-strobe and ignored-write cases.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Register layout (byte offsets)
  localparam int unsigned MSG_BASE    = 32'h040;
  localparam int unsigned CNT_BASE    = 32'h0C0;
  localparam int unsigned BANK_BASE   = 32'h100;
  localparam int unsigned BANK_STRIDE = 32'h010;

  // Register inside a user bank, selected by address bits [3:2]
  typedef enum logic [1:0] {
    BK_RAW  = 2'd0,
    BK_CLR  = 2'd1,
    BK_ESET = 2'd2,
    BK_ECLR = 2'd3
  } bank_reg_e;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int unsigned N_MBOX = 10,
  parameter int unsigned N_USER = 4,
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_MBOX-1:0] msg_sel,
  output logic [N_MBOX-1:0] cnt_sel,
  output logic [N_USER-1:0] bank_sel,
  output bank_reg_e         bank_reg
);

  for (genvar m = 0; m < N_MBOX; m++) begin : g_mbox
    localparam logic [ADDR_W-1:0] MSG_A = ADDR_W'(MSG_BASE + 4 * m);
    localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(CNT_BASE + 4 * m);
    assign msg_sel[m] = (addr == MSG_A);
    assign cnt_sel[m] = (addr == CNT_A);
  end

  for (genvar u = 0; u < N_USER; u++) begin : g_bank
    localparam logic [ADDR_W-1:0] BANK_A = ADDR_W'(BANK_BASE + BANK_STRIDE * u);
    assign bank_sel[u] = (addr[ADDR_W-1:4] == BANK_A[ADDR_W-1:4]) && (addr[1:0] == 2'b00);
  end

  assign bank_reg = bank_reg_e'(addr[3:2]);

endmodule

// File: rtl/mbx_queue.sv
module mbx_queue #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    head,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             full, empty, push_ok, pop_ok;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign ovf     = push && full;
  assign head    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);  // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == FULL_CNT));  // R4
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == '0));  // R2

endmodule

// File: rtl/mbx_user_bank.sv
module mbx_user_bank #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_src,
  input  logic [DW-1:0] st_clr,
  input  logic [DW-1:0] en_set,
  input  logic [DW-1:0] en_clr,
  output logic [DW-1:0] status,
  output logic [DW-1:0] enable,
  output logic          irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      // event sources win over a clear in the same cycle
      status <= (status & ~st_clr) | set_src;
      enable <= (enable | en_set) & ~en_clr;
      irq    <= |(status & enable);
    end
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_src) |=> ((status & $past(set_src)) == $past(set_src)));  // R5
  AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (|(st_clr & ~set_src)) |=> ((status & $past(st_clr & ~set_src)) == '0));  // R6
  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_set) |=> ((enable & $past(en_set)) == $past(en_set)));  // R7
  AST_ENABLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_clr) |=> ((enable & $past(en_clr)) == '0));  // R8
  AST_IRQ_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & enable) != '0) |=> irq);  // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & enable) == '0) |=> !irq);  // R9

endmodule

// File: rtl/mbx_hub.sv
module mbx_hub
  import mbx_pkg::*;
#(
  parameter int unsigned N_MBOX = 10,
  parameter int unsigned N_USER = 4,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned MAP_W  = 4,
  // receiving user of mailbox M in field [MAP_W*M +: MAP_W]
  parameter logic [N_MBOX*MAP_W-1:0] RX_MAP = 40'h1010321320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [N_USER-1:0] irq
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [N_MBOX-1:0] msg_sel, cnt_sel;
  logic [N_USER-1:0] bank_sel;
  bank_reg_e         bank_reg;
  logic              rd_eff;

  logic [DW-1:0]     q_head  [N_MBOX];
  logic [CNT_W-1:0]  q_count [N_MBOX];
  logic [N_MBOX-1:0] q_push, q_pop, q_ovf, q_nonempty;

  logic [DW-1:0]     usr_status [N_USER];
  logic [DW-1:0]     usr_enable [N_USER];

  // a write strobe takes precedence; a read alongside it removes nothing
  assign rd_eff = bus_rd && !bus_wr;

  mbx_decode #(
    .N_MBOX (N_MBOX),
    .N_USER (N_USER),
    .ADDR_W (ADDR_W)
  ) u_decode (
    .addr     (bus_addr),
    .msg_sel  (msg_sel),
    .cnt_sel  (cnt_sel),
    .bank_sel (bank_sel),
    .bank_reg (bank_reg)
  );

  for (genvar m = 0; m < N_MBOX; m++) begin : g_mbox
    assign q_push[m]     = bus_wr && msg_sel[m];
    assign q_pop[m]      = rd_eff && msg_sel[m];
    assign q_nonempty[m] = (q_count[m] != '0);

    mbx_queue #(
      .DEPTH (DEPTH),
      .DW    (DW)
    ) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push[m]),
      .pop   (q_pop[m]),
      .wdata (bus_wdata),
      .head  (q_head[m]),
      .count (q_count[m]),
      .ovf   (q_ovf[m])
    );

    AST_WRITE_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && msg_sel[m] && q_count[m] != FULL_CNT)
        |=> (q_count[m] == $past(q_count[m]) + CNT_W'(1)));  // R11
  end

  for (genvar u = 0; u < N_USER; u++) begin : g_user
    logic [DW-1:0] set_vec, clr_vec, eset_vec, eclr_vec;
    logic          bank_wr;

    always_comb begin
      set_vec = '0;
      for (int m = 0; m < N_MBOX; m++) begin
        if (int'(RX_MAP[m*MAP_W +: MAP_W]) == u) begin
          set_vec[2*m]   = q_nonempty[m];
          set_vec[2*m+1] = q_ovf[m];
        end
      end
    end

    assign bank_wr  = bus_wr && bank_sel[u];
    assign clr_vec  = (bank_wr && bank_reg == BK_CLR)  ? bus_wdata : '0;
    assign eset_vec = (bank_wr && bank_reg == BK_ESET) ? bus_wdata : '0;
    assign eclr_vec = (bank_wr && bank_reg == BK_ECLR) ? bus_wdata : '0;

    mbx_user_bank #(
      .DW (DW)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_src (set_vec),
      .st_clr  (clr_vec),
      .en_set  (eset_vec),
      .en_clr  (eclr_vec),
      .status  (usr_status[u]),
      .enable  (usr_enable[u]),
      .irq     (irq[u])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int m = 0; m < N_MBOX; m++) begin
      if (msg_sel[m] && q_nonempty[m]) bus_rdata = q_head[m];
      if (cnt_sel[m])                  bus_rdata = DW'(q_count[m]);
    end
    for (int u = 0; u < N_USER; u++) begin
      if (bank_sel[u]) begin
        case (bank_reg)
          BK_RAW:  bus_rdata = usr_status[u];
          BK_CLR:  bus_rdata = usr_status[u] & usr_enable[u];
          default: bus_rdata = usr_enable[u];
        endcase
      end
    end
  end

  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_eff && ((msg_sel & ~q_nonempty) != '0)) |-> (bus_rdata == '0));  // R2

endmodule

// File: tb/mbx_hub_test.sv
module mbx_hub_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_W = 2'd0;
  localparam logic [1:0] OP_R = 2'd1;

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [31:0] data;   // write data, or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{OP_W, 12'h108, 32'h1,        4'd7},
    '{OP_R, 12'h108, 32'h1,        4'd7},
    '{OP_W, 12'h040, 32'hA1A1A1A1, 4'd2},
    '{OP_W, 12'h040, 32'hA2A2A2A2, 4'd2},
    '{OP_R, 12'h0C0, 32'h2,        4'd3},
    '{OP_R, 12'h100, 32'h1,        4'd5},
    '{OP_R, 12'h040, 32'hA1A1A1A1, 4'd2},
    '{OP_R, 12'h040, 32'hA2A2A2A2, 4'd2},
    '{OP_R, 12'h0C0, 32'h0,        4'd3},
    '{OP_R, 12'h040, 32'h0,        4'd2},
    '{OP_R, 12'h100, 32'h1,        4'd5},
    '{OP_W, 12'h104, 32'h0,        4'd6},
    '{OP_R, 12'h100, 32'h1,        4'd6},
    '{OP_W, 12'h104, 32'h1,        4'd6},
    '{OP_R, 12'h100, 32'h0,        4'd6},
    '{OP_W, 12'h10C, 32'h1,        4'd8},
    '{OP_R, 12'h108, 32'h0,        4'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_bad = 0;

  mbx_hub uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 irq after reset", {28'h0, irq}, 32'h0);
    rd_chk(12'h0C0, 32'h0, "R1 count after reset");
    rd_chk(12'h100, 32'h0, "R1 status after reset");
    rd_chk(12'h108, 32'h0, "R1 enable after reset");

    // vector table: mailbox 0 into user 0
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].op == OP_W) begin
        wr(VECS[i].addr, VECS[i].data);
      end else begin
        rd_chk(VECS[i].addr, VECS[i].data, $sformatf("R%0d vector %0d", VECS[i].req, i));
      end
    end
    chk("R9 irq 0 after disable", {28'h0, irq}, 32'h0);

    // R4: fill mailbox 3 (user 1) past depth
    for (int k = 0; k < 5; k++) wr(12'h04C, 32'h300 + k);
    rd_chk(12'h0CC, 32'h4, "R4 count held at depth");
    rd_chk(12'h110, 32'hC0, "R4 overflow and new bits for user 1");

    // R10: other banks untouched
    rd_chk(12'h100, 32'h0, "R10 user 0 status");
    rd_chk(12'h120, 32'h0, "R10 user 2 status");
    rd_chk(12'h130, 32'h0, "R10 user 3 status");

    // R9: enable new-message bit of mailbox 3
    wr(12'h118, 32'h40);
    chk("R9 irq not yet", {28'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq raised", {28'h0, irq}, 32'h2);

    // R5: clearing while non-empty keeps the bit
    wr(12'h114, 32'h40);
    rd_chk(12'h110, 32'hC0, "R5 new bit held while non-empty");
    wr(12'h114, 32'h80);
    rd_chk(12'h110, 32'h40, "R6 overflow bit cleared");
    rd_chk(12'h114, 32'h40, "R6 masked status view");

    // R8: disable, interrupt falls one cycle later
    wr(12'h11C, 32'h40);
    chk("R9 irq still high", {28'h0, irq}, 32'h2);
    @(negedge clk);
    chk("R8 irq low after enable clear", {28'h0, irq}, 32'h0);
    rd_chk(12'h11C, 32'h0, "R8 enable mask read");

    // R2/R4: drain in order, fifth word was dropped
    for (int k = 0; k < 4; k++) rd_chk(12'h04C, 32'h300 + k, "R2 order after fill");
    rd_chk(12'h04C, 32'h0, "R4 dropped word absent");
    rd_chk(12'h0CC, 32'h0, "R3 count after drain");

    // R11: both strobes on mailbox 4
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 12'h050; bus_wdata = 32'h55 + 32'(k) * 32'h11;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
    end
    rd_chk(12'h0D0, 32'h2, "R11 write with read strobe pops nothing");
    rd_chk(12'h120, 32'h100, "R10 mailbox 4 routes to user 2");
    rd_chk(12'h050, 32'h55, "R11 head word kept");
    rd_chk(12'h3F0, 32'h0, "R11 undecoded read");
    wr(12'h0D0, 32'hFFFF);
    wr(12'h120, 32'hFFFF);
    rd_chk(12'h0D0, 32'h1, "R11 count write ignored");
    rd_chk(12'h120, 32'h100, "R11 raw status write ignored");
    chk("R9 irq stays low without enable", {28'h0, irq}, 32'h0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule